// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

This block is the compute element of a programmable fabric built from two-level logic. It takes a vector of data inputs, forms a set of product terms from selected input literals, combines those terms into a small number of outputs, and lets each output be taken either straight from the OR stage or from a flip-flop that captures it. The whole function is set by a serial configuration chain. The chain is loaded one bit per clock while the configure enable is high. While it is high, every output is forced low.

Two build-time variants change the shape of the planes. With folding enabled, each product term sees only half of the inputs: even-numbered terms see the lower half and odd-numbered terms see the upper half. This halves the AND-plane configuration. With the fixed-OR variant, the OR stage has no configuration bits. Each output ORs its own dedicated, non-overlapping group of consecutive terms. The default size is 10 inputs, 12 terms and 4 outputs.

Top module: `pla_cell`

## Requirements
- R1: Each literal of a term is set by a 2-bit code: 00 means not used, 01 means the input in true form, 10 means the complemented input. A term is the AND of all its used literals.
- R2: A term with no literal in use evaluates to 0 and never drives an output high.
- R3: Code 11 on any literal of a term forces that term to 0 for every input value.
- R4: In the programmable OR variant, output o is the OR of every term t whose OR bit (o,t) is 1. A single term may feed several outputs, and an output with no active terms is 0.
- R5: In the folded variant, a term has NUM_IN/2 literals. Literal l of even term t reads input l, and literal l of odd term t reads input NUM_IN/2 + l.
- R6: In the fixed-OR variant, output o is the OR of terms o*G to o*G+G-1, where G = NUM_TERMS/NUM_OUT, and the chain carries no OR bits.
- R7: When the select bit of output o is 1, dout[o] shows the OR result that was captured at the previous rising clock edge. When the select bit is 0, dout[o] follows the inputs combinationally. The output flip-flops are cleared while configuring, so a registered output reads 0 in the first cycle after cfg_en falls.
- R8: While cfg_en is high, dout is all zeros.
- R9: After reset, the configuration and the output flip-flops are all zero, so dout is 0 for any input.
- R10: Each cycle with cfg_en high shifts in one cfg_in bit. The bits go in this order: first the AND-plane bits (term by term, then literal by literal, with bit 0 of each code first), next the OR bits (output by output, then term by term; this section is absent in the fixed-OR variant), and last one select bit per output. While cfg_en is low, cfg_in has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_en | input | 1 | Configure mode: shifts the chain and forces the outputs low |
| cfg_in | input | 1 | Serial configuration bit |
| din | input | NUM_IN | Logic inputs |
| dout | output | NUM_OUT | Logic outputs |

## Verification
The bench goes after the term corner cases. An empty term that wrongly evaluated as a logical 1 would drive its outputs high all the time. A term with both literals of one input selected would go high when that input is shared with another literal. A term shared between two outputs would be lost on one of them if the OR plane were wired per output. In the folded, fixed-OR instance, a term reading the wrong half of the inputs, or an output ORing the wrong group of terms, shows up in directed vectors that set a single input bit. Any mistake in the chain order would scramble every configuration, and it is caught by comparing random configurations against an independent sum-of-products model. Timing of the registered path is checked around the end of configuration: a flip-flop that is not cleared, or one that is off by a cycle, would show the stale value or the value one cycle early.

// File: rtl/pla_cell_pkg.sv
`timescale 1ns/1ps
package pla_cell_pkg;

  typedef enum logic [1:0] {
    LIT_OFF  = 2'b00,
    LIT_POS  = 2'b01,
    LIT_NEG  = 2'b10,
    LIT_KILL = 2'b11
  } lit_code_e;

  // literals carried by one product term
  function automatic int lits_per_term(input int num_in, input bit fold);
    return fold ? (num_in / 2) : num_in;
  endfunction

  // first input index seen by term t
  function automatic int term_base(input int num_in, input bit fold, input int t);
    if (fold && (t % 2 == 1)) return num_in - (num_in / 2);
    return 0;
  endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
`timescale 1ns/1ps
module pla_cfg_chain #(
  parameter int LEN = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_en,
  input  logic           cfg_in,
  output logic [LEN-1:0] cfg_q
);

  logic [LEN-1:0] chain_r;
  logic [LEN-1:0] chain_d;

  // new bit enters at the top; the first bit loaded ends at index 0
  always_comb begin
    chain_d = chain_r;
    if (cfg_en) chain_d = {cfg_in, chain_r[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_r <= '0;
    else if (cfg_en) chain_r <= chain_d;
  end

  assign cfg_q = chain_r;

endmodule

// File: rtl/pla_and_plane.sv
`timescale 1ns/1ps
module pla_and_plane
  import pla_cell_pkg::*;
#(
  parameter  int NUM_IN    = 10,
  parameter  int NUM_TERMS = 12,
  parameter  bit FOLD_EN   = 1'b0,
  localparam int LITS      = lits_per_term(NUM_IN, FOLD_EN),
  localparam int CFG_W     = NUM_TERMS * LITS * 2
) (
  input  logic [NUM_IN-1:0]    din,
  input  logic [CFG_W-1:0]     and_cfg,
  output logic [NUM_TERMS-1:0] terms
);

  for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
    localparam int BASE = term_base(NUM_IN, FOLD_EN, t);
    logic [LITS-1:0] used;
    logic [LITS-1:0] pass;

    for (genvar l = 0; l < LITS; l++) begin : g_lit
      lit_code_e code;
      logic      used_l;
      logic      pass_l;
      logic      x;

      assign code = lit_code_e'(and_cfg[(t*LITS + l)*2 +: 2]);
      assign x    = din[BASE + l];

      always_comb begin
        unique case (code)
          LIT_OFF:  begin used_l = 1'b0; pass_l = 1'b1; end
          LIT_POS:  begin used_l = 1'b1; pass_l = x;    end
          LIT_NEG:  begin used_l = 1'b1; pass_l = ~x;   end
          LIT_KILL: begin used_l = 1'b1; pass_l = 1'b0; end
        endcase
      end

      assign used[l] = used_l;
      assign pass[l] = pass_l;
    end

    // an empty term is 0, not the AND identity
    assign terms[t] = (|used) & (&pass);
  end

endmodule

// File: rtl/pla_or_plane.sv
`timescale 1ns/1ps
module pla_or_plane #(
  parameter  int NUM_TERMS = 12,
  parameter  int NUM_OUT   = 4,
  parameter  bit FIXED_OR  = 1'b0,
  localparam int CFG_W     = FIXED_OR ? 1 : NUM_TERMS * NUM_OUT,
  localparam int GROUP     = NUM_TERMS / NUM_OUT
) (
  input  logic [NUM_TERMS-1:0] terms,
  input  logic [CFG_W-1:0]     or_cfg,
  output logic [NUM_OUT-1:0]   sums
);

  if (FIXED_OR) begin : g_fixed
    logic unused_cfg;
    assign unused_cfg = ^or_cfg;

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign sums[o] = |terms[o*GROUP +: GROUP];
    end

    if (NUM_TERMS % NUM_OUT != 0) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^terms[NUM_TERMS-1:NUM_OUT*GROUP];
    end
  end else begin : g_prog
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      assign sums[o] = |(terms & or_cfg[o*NUM_TERMS +: NUM_TERMS]);
    end
  end

endmodule

// File: rtl/pla_macrocell.sv
`timescale 1ns/1ps
module pla_macrocell #(
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic [NUM_OUT-1:0] sums,
  input  logic [NUM_OUT-1:0] reg_sel,
  output logic [NUM_OUT-1:0] dout
);

  logic [NUM_OUT-1:0] cap_r;
  logic [NUM_OUT-1:0] cap_d;

  // flops are held clear while the planes are being rewritten
  always_comb begin
    cap_d = sums;
    if (cfg_en) cap_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_r <= '0;
    else        cap_r <= cap_d;
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    assign dout[o] = ~cfg_en & (reg_sel[o] ? cap_r[o] : sums[o]);
  end

endmodule

// File: rtl/pla_cell.sv
`timescale 1ns/1ps
module pla_cell
  import pla_cell_pkg::*;
#(
  parameter int NUM_IN    = 10,
  parameter int NUM_TERMS = 12,
  parameter int NUM_OUT   = 4,
  parameter bit FOLD_EN   = 1'b0,
  parameter bit FIXED_OR  = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_en,
  input  logic               cfg_in,
  input  logic [NUM_IN-1:0]  din,
  output logic [NUM_OUT-1:0] dout
);

  localparam int LITS      = lits_per_term(NUM_IN, FOLD_EN);
  localparam int AND_W     = NUM_TERMS * LITS * 2;
  localparam int OR_CH_W   = FIXED_OR ? 0 : NUM_TERMS * NUM_OUT;
  localparam int OR_PORT_W = FIXED_OR ? 1 : NUM_TERMS * NUM_OUT;
  localparam int SEL_LSB   = AND_W + OR_CH_W;
  localparam int CFG_LEN   = SEL_LSB + NUM_OUT;

  // reset asserts at once, leaves on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [CFG_LEN-1:0]   cfg_q;
  logic [AND_W-1:0]     and_cfg;
  logic [OR_PORT_W-1:0] or_cfg;
  logic [NUM_OUT-1:0]   reg_sel;
  logic [NUM_TERMS-1:0] terms;
  logic [NUM_OUT-1:0]   sums;

  pla_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .cfg_en (cfg_en),
    .cfg_in (cfg_in),
    .cfg_q  (cfg_q)
  );

  assign and_cfg = cfg_q[0 +: AND_W];
  assign reg_sel = cfg_q[SEL_LSB +: NUM_OUT];

  if (FIXED_OR) begin : g_or_fixed
    assign or_cfg = '0;
  end else begin : g_or_prog
    assign or_cfg = cfg_q[AND_W +: OR_CH_W];
  end

  pla_and_plane #(
    .NUM_IN    (NUM_IN),
    .NUM_TERMS (NUM_TERMS),
    .FOLD_EN   (FOLD_EN)
  ) u_and (
    .din     (din),
    .and_cfg (and_cfg),
    .terms   (terms)
  );

  pla_or_plane #(
    .NUM_TERMS (NUM_TERMS),
    .NUM_OUT   (NUM_OUT),
    .FIXED_OR  (FIXED_OR)
  ) u_or (
    .terms  (terms),
    .or_cfg (or_cfg),
    .sums   (sums)
  );

  pla_macrocell #(.NUM_OUT(NUM_OUT)) u_mc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .cfg_en  (cfg_en),
    .sums    (sums),
    .reg_sel (reg_sel),
    .dout    (dout)
  );

endmodule

// File: rtl/pla_cell_chk.sv
`timescale 1ns/1ps
module pla_cell_chk #(
  parameter int NUM_TERMS = 12,
  parameter int NUM_OUT   = 4,
  parameter int CFG_LEN   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_en,
  input logic [CFG_LEN-1:0]   cfg_q,
  input logic [NUM_TERMS-1:0] terms,
  input logic [NUM_OUT-1:0]   sums,
  input logic [NUM_OUT-1:0]   reg_sel,
  input logic [NUM_OUT-1:0]   dout
);

  AST_QUIET_IN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |-> dout == '0); // R8

  AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_q)); // R10

  AST_REG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_en) && !cfg_en) |-> (dout & reg_sel) == '0); // R7

  AST_REG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !$past(cfg_en)) |-> (dout & reg_sel) == ($past(sums) & reg_sel)); // R7

  AST_DEAD_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && terms == '0) |-> (dout & ~reg_sel) == '0); // R4

endmodule

bind pla_cell pla_cell_chk #(
  .NUM_TERMS (NUM_TERMS),
  .NUM_OUT   (NUM_OUT),
  .CFG_LEN   (CFG_LEN)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .cfg_en  (cfg_en),
  .cfg_q   (cfg_q),
  .terms   (terms),
  .sums    (sums),
  .reg_sel (reg_sel),
  .dout    (dout)
);

// File: tb/pla_cell_test.sv
`timescale 1ns/1ps
module pla_cell_test;

  localparam int NI = 10;
  localparam int NT = 12;
  localparam int NO = 4;
  localparam int G  = NT / NO;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_en_a, cfg_in_a, cfg_en_b, cfg_in_b;
  logic [NI-1:0] din;
  logic [NO-1:0] dout_a, dout_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pla_cell #(.NUM_IN(NI), .NUM_TERMS(NT), .NUM_OUT(NO), .FOLD_EN(1'b0), .FIXED_OR(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_a), .cfg_in(cfg_in_a), .din(din), .dout(dout_a));

  pla_cell #(.NUM_IN(NI), .NUM_TERMS(NT), .NUM_OUT(NO), .FOLD_EN(1'b1), .FIXED_OR(1'b1)) uut_pal (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_b), .cfg_in(cfg_in_b), .din(din), .dout(dout_b));

  logic [1:0]    lit  [NT][NI];
  logic          orm  [NO][NT];
  logic [NO-1:0] rsel;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] model(input bit pal, input logic [NI-1:0] x);
    logic [NT-1:0] tv;
    logic [NO-1:0] r;
    int nl;
    nl = pal ? NI/2 : NI;
    for (int t = 0; t < NT; t++) begin
      int  base;
      bit  any;
      bit  v;
      base = (pal && (t % 2 == 1)) ? NI - NI/2 : 0;
      any = 0; v = 1;
      for (int l = 0; l < nl; l++) begin
        if (lit[t][l][0]) begin any = 1; v = v & x[base+l];  end
        if (lit[t][l][1]) begin any = 1; v = v & ~x[base+l]; end
      end
      tv[t] = any & v;
    end
    r = '0;
    for (int o = 0; o < NO; o++)
      for (int t = 0; t < NT; t++)
        if (pal) begin
          if (t >= o*G && t < o*G + G && tv[t]) r[o] = 1'b1;
        end else if (orm[o][t] && tv[t]) r[o] = 1'b1;
    return r;
  endfunction

  task automatic clear_cfg();
    for (int t = 0; t < NT; t++) for (int l = 0; l < NI; l++) lit[t][l] = 2'b00;
    for (int o = 0; o < NO; o++) for (int t = 0; t < NT; t++) orm[o][t] = 1'b0;
    rsel = '0;
  endtask

  task automatic rand_cfg();
    for (int t = 0; t < NT; t++)
      for (int l = 0; l < NI; l++) begin
        int r;
        r = $urandom % 16;
        lit[t][l] = (r < 10) ? 2'b00 : (r < 13) ? 2'b01 : (r < 15) ? 2'b10 : 2'b11;
      end
    for (int o = 0; o < NO; o++) for (int t = 0; t < NT; t++) orm[o][t] = ($urandom % 3 == 0);
    rsel = NO'($urandom);
  endtask

  // shifts the configuration in the order of R10, checking R8 halfway
  task automatic load(input bit pal);
    logic [511:0] s;
    int len, nl;
    len = 0;
    nl = pal ? NI/2 : NI;
    for (int t = 0; t < NT; t++)
      for (int l = 0; l < nl; l++) begin
        s[len] = lit[t][l][0]; s[len+1] = lit[t][l][1]; len += 2;
      end
    if (!pal)
      for (int o = 0; o < NO; o++) for (int t = 0; t < NT; t++) begin s[len] = orm[o][t]; len++; end
    for (int o = 0; o < NO; o++) begin s[len] = rsel[o]; len++; end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pal) begin cfg_en_b = 1; cfg_in_b = s[i]; end
      else     begin cfg_en_a = 1; cfg_in_a = s[i]; end
      if (i == len/2) begin
        #1 check("R8", pal ? dout_b : dout_a, '0);
      end
    end
    @(negedge clk);
    cfg_en_a = 0; cfg_en_b = 0; cfg_in_a = 0; cfg_in_b = 0;
  endtask

  // combinational part right after the input change, full output after the edge
  task automatic run_vec(input bit pal, input logic [NI-1:0] x, input string req);
    logic [NO-1:0] e;
    @(negedge clk);
    din = x;
    e = model(pal, x);
    #1 check(req, (pal ? dout_b : dout_a) & ~rsel, e & ~rsel);
    @(posedge clk);
    #1 check(req, pal ? dout_b : dout_a, e);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    #1;
    check("R9", dout_a, '0);
    check("R9", dout_b, '0);
  endtask

  // R1 R2 R3 R4: hand-worked vectors on the programmable instance
  task automatic t_literals();
    clear_cfg();
    lit[0][0] = 2'b01; lit[0][1] = 2'b10; orm[0][0] = 1;
    orm[1][1] = 1;
    lit[2][3] = 2'b11; lit[2][4] = 2'b01; orm[2][2] = 1;
    lit[3][9] = 2'b01; orm[3][3] = 1; orm[0][3] = 1;
    load(0);
    @(negedge clk); din = 10'h001; #1 check("R1", dout_a, 4'b0001);
    @(negedge clk); din = 10'h003; #1 check("R1", dout_a, 4'b0000);
    @(negedge clk); din = 10'h3FF; #1 check("R2", dout_a, 4'b1001);
    @(negedge clk); din = 10'h018; #1 check("R3", dout_a, 4'b0000);
    @(negedge clk); din = 10'h200; #1 check("R4", dout_a, 4'b1001);
    // R10: cfg_in toggling with cfg_en low leaves the function unchanged
    for (int i = 0; i < 40; i++) begin @(negedge clk); cfg_in_a = i[0]; end
    @(negedge clk); cfg_in_a = 0; din = 10'h001; #1 check("R10", dout_a, 4'b0001);
  endtask

  // R5 R6: folded, fixed-OR instance
  task automatic t_folded();
    clear_cfg();
    lit[0][0] = 2'b01;
    lit[1][0] = 2'b01;
    lit[4][4] = 2'b10;
    lit[7][4] = 2'b01;
    load(1);
    @(negedge clk); din = 10'h000; #1 check("R6", dout_b, 4'b0010);
    @(negedge clk); din = 10'h001; #1 check("R5", dout_b, 4'b0011);
    @(negedge clk); din = 10'h020; #1 check("R5", dout_b, 4'b0011);
    @(negedge clk); din = 10'h010; #1 check("R5", dout_b, 4'b0000);
    @(negedge clk); din = 10'h200; #1 check("R6", dout_b, 4'b0110);
  endtask

  // R7: cleared flops after configuration, then one-cycle capture
  task automatic t_registered();
    clear_cfg();
    lit[0][0] = 2'b01;
    for (int o = 0; o < NO; o++) orm[o][0] = 1;
    rsel = 4'b1010;
    @(negedge clk); din = 10'h3FF;
    load(0);
    #1 check("R7", dout_a, 4'b0101);
    @(negedge clk); din = 10'h000;
    @(negedge clk); #1 check("R7", dout_a, 4'b0000);
    din = 10'h001; #1 check("R7", dout_a, 4'b0101);
    @(posedge clk); #1 check("R7", dout_a, 4'b1111);
    @(negedge clk); din = 10'h000; #1 check("R7", dout_a, 4'b1010);
    @(posedge clk); #1 check("R7", dout_a, 4'b0000);
  endtask

  task automatic t_random(input bit pal);
    for (int c = 0; c < 20; c++) begin
      rand_cfg();
      load(pal);
      for (int v = 0; v < 30; v++) run_vec(pal, NI'($urandom), pal ? "R6" : "R4");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_en_a = 0; cfg_in_a = 0; cfg_en_b = 0; cfg_in_b = 0;
    din = '1;
    rsel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_literals();
    t_folded();
    t_registered();
    t_random(0);
    t_random(1);
    finish_run();
  end

endmodule